// File: doc/BRIEF.md
# Virtual Segment Decoder

This block sorts each 32-bit virtual address into one of five fixed regions and checks it against the current privilege level (kernel, supervisor or user). Each accepted request then takes one of three paths. It may be resolved on the spot into a physical address with read and write permission. It may be handed to an external translation lookaside buffer (TLB). Or it may be refused as an address error.

The region is selected by the top three address bits. The low half of the space is open to every privilege level. It is translated by the TLB, except while the error-level flag is raised: the address is then passed through unchanged as its own physical address. Two kernel windows at 0x80000000 and 0xA0000000 drop their region bits to form a physical address. The region at 0xC0000000 is translated for kernel and supervisor. The region at 0xE0000000 is translated for kernel only.

The block holds at most one TLB request in flight and lowers `req_ready` while that request is open. The TLB's answer is copied to the result port. Every accepted request produces exactly one registered result pulse, and results come out in the order the requests were accepted.

Top module: `virt_seg_decoder`

## Requirements
- R1: After reset `out_valid` and `tlb_req_valid` are 0 and `req_ready` is 1.
- R2: An accepted address with bit 31 = 0 and `req_erl` = 0 raises `tlb_req_valid` for exactly one cycle, on the cycle after acceptance, with `tlb_req_vaddr` equal to the address. No result appears before the TLB answers.
- R3: An accepted address with bit 31 = 0 and `req_erl` = 1 gives, on the cycle after acceptance, code 0, `out_paddr` equal to the address and `out_perm` = 2'b11 (bit 1 write, bit 0 read), from any mode. No TLB request is made.
- R4: Top bits 3'b100 in kernel mode give code 0, `out_paddr` = address − 0x80000000 and `out_perm` = 2'b11, one cycle after acceptance.
- R5: Top bits 3'b101 in kernel mode give code 0, `out_paddr` = address − 0xA0000000 and `out_perm` = 2'b11, one cycle after acceptance.
- R6: Top bits 3'b100, 3'b101 or 3'b111 from supervisor or user mode give code 1 (bad address), `out_paddr` = 0 and `out_perm` = 2'b00, one cycle after acceptance, with no TLB request.
- R7: Top bits 3'b110 go to the TLB in kernel or supervisor mode. In user mode they give code 1 with no TLB request.
- R8: Top bits 3'b111 in kernel mode go to the TLB.
- R9: `tlb_rsp_valid` while a request is open puts `tlb_rsp_code`, `tlb_rsp_paddr` and `tlb_rsp_perm` on the result port on the next cycle. `req_ready` is 0 from the cycle after a TLB-bound request is accepted until that response has been taken.
- R10: `req_mode` encodes 2'b00 kernel, 2'b01 supervisor and 2'b10 user. 2'b11 is treated as user.
- R11: Each accepted request yields exactly one `out_valid` pulse, and results come out in acceptance order. Code 0 means match and code 1 means bad address. Any other code is whatever the TLB returned.
- R12: `req_valid` while `req_ready` is 0 is ignored: it produces no result and no TLB request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | ADDR_W | Virtual address |
| req_mode | input | 2 | Privilege level code |
| req_erl | input | 1 | Error-level flag |
| tlb_req_valid | output | 1 | One-cycle TLB lookup strobe |
| tlb_req_vaddr | output | ADDR_W | Address to translate |
| tlb_rsp_valid | input | 1 | TLB answer present |
| tlb_rsp_code | input | CODE_W | TLB result code |
| tlb_rsp_paddr | input | ADDR_W | TLB physical address |
| tlb_rsp_perm | input | 2 | TLB permission, bit 1 write, bit 0 read |
| out_valid | output | 1 | One-cycle result pulse |
| out_code | output | CODE_W | Result code |
| out_paddr | output | ADDR_W | Physical address |
| out_perm | output | 2 | Permission, bit 1 write, bit 0 read |

## Verification
The bench builds the block with its default ADDR_W = 32 and CODE_W = 3. At these values the real region boundaries, such as 0x7FFFFFFF/0x80000000 and 0xDFFFFFFF/0xE0000000, can be probed directly. The three-bit code also has room for the TLB's own codes 2, 3 and 4 beside match and bad address. The bench's TLB model answers with zero-cycle and multi-cycle latency. This exercises a response in the same cycle as the lookup strobe, as well as a long wait during which stray requests must be dropped.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam logic [1:0] MODE_KERNEL = 2'b00;
  localparam logic [1:0] MODE_SUPER  = 2'b01;

  localparam int RES_MATCH   = 0;
  localparam int RES_BADADDR = 1;

  localparam logic [1:0] PERM_RW   = 2'b11;
  localparam logic [1:0] PERM_NONE = 2'b00;

  typedef enum logic [1:0] {
    RT_FAULT  = 2'd0,
    RT_DIRECT = 2'd1,
    RT_TLB    = 2'd2
  } route_e;
endpackage

// File: rtl/vsd_classify.sv
module vsd_classify
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        mode,
  input  logic              erl,
  output route_e            route,
  output logic [ADDR_W-1:0] direct_paddr,
  output logic [CODE_W-1:0] direct_code,
  output logic [1:0]        direct_perm
);
  localparam int SEG_BITS = 3;
  localparam int NSEG     = 1 << SEG_BITS;
  localparam int OFF_W    = ADDR_W - SEG_BITS;

  logic [SEG_BITS-1:0] seg_id;
  logic                lvl_kernel;
  logic                lvl_super;
  logic [NSEG-1:0]     hit_allowed;
  logic [NSEG-1:0]     hit_mapped;
  logic [NSEG-1:0]     hit_open;

  assign seg_id     = vaddr[ADDR_W-1 -: SEG_BITS];
  assign lvl_kernel = (mode == MODE_KERNEL);
  assign lvl_super  = (mode == MODE_SUPER);

  // Per-region policy derived from the region index.
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam bit OPEN   = (g < NSEG / 2);
    localparam bit SUP_OK = OPEN || (g == NSEG - 2);
    localparam bit MAPPED = OPEN || (g >= NSEG - 2);
    logic here;
    assign here           = (seg_id == SEG_BITS'(g));
    assign hit_allowed[g] = here & (lvl_kernel | (lvl_super & SUP_OK) | OPEN);
    assign hit_mapped[g]  = here & MAPPED;
    assign hit_open[g]    = here & OPEN;
  end

  always_comb begin
    route        = RT_FAULT;
    direct_paddr = '0;
    direct_code  = CODE_W'(RES_BADADDR);
    direct_perm  = PERM_NONE;
    if (|hit_allowed) begin
      if ((|hit_open) && erl) begin
        route        = RT_DIRECT;
        direct_paddr = vaddr;
        direct_code  = CODE_W'(RES_MATCH);
        direct_perm  = PERM_RW;
      end else if (|hit_mapped) begin
        route        = RT_TLB;
        direct_code  = CODE_W'(RES_MATCH);
      end else begin
        route        = RT_DIRECT;
        direct_paddr = {{SEG_BITS{1'b0}}, vaddr[OFF_W-1:0]};
        direct_code  = CODE_W'(RES_MATCH);
        direct_perm  = PERM_RW;
      end
    end
  end
endmodule

// File: rtl/vsd_tlb_port.sv
module vsd_tlb_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              rsp_valid,
  output logic              tlb_req_valid,
  output logic [ADDR_W-1:0] tlb_req_vaddr,
  output logic              busy,
  output logic              rsp_take
);
  assign rsp_take = busy & rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      tlb_req_valid <= 1'b0;
      tlb_req_vaddr <= '0;
    end else begin
      tlb_req_valid <= issue;
      if (issue) begin
        busy          <= 1'b1;
        tlb_req_vaddr <= vaddr;
      end else if (rsp_take) begin
        busy <= 1'b0;
      end
    end
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    issue |-> !busy); // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tlb_req_valid |=> !tlb_req_valid); // R2
endmodule

// File: rtl/vsd_result_reg.sv
module vsd_result_reg #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              direct_load,
  input  logic [CODE_W-1:0] direct_code,
  input  logic [ADDR_W-1:0] direct_paddr,
  input  logic [1:0]        direct_perm,
  input  logic              rsp_take,
  input  logic [CODE_W-1:0] rsp_code,
  input  logic [ADDR_W-1:0] rsp_paddr,
  input  logic [1:0]        rsp_perm,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_paddr,
  output logic [1:0]        out_perm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_paddr <= '0;
      out_perm  <= '0;
    end else begin
      out_valid <= direct_load | rsp_take;
      if (rsp_take) begin
        out_code  <= rsp_code;
        out_paddr <= rsp_paddr;
        out_perm  <= rsp_perm;
      end else if (direct_load) begin
        out_code  <= direct_code;
        out_paddr <= direct_paddr;
        out_perm  <= direct_perm;
      end
    end
  end

  AST_RSP_FORWARD: assert property (@(posedge clk) disable iff (rst)
    rsp_take |=> out_valid && out_code == $past(rsp_code)
                 && out_paddr == $past(rsp_paddr) && out_perm == $past(rsp_perm)); // R9
endmodule

// File: rtl/virt_seg_decoder.sv
module virt_seg_decoder
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_mode,
  input  logic              req_erl,
  output logic              tlb_req_valid,
  output logic [ADDR_W-1:0] tlb_req_vaddr,
  input  logic              tlb_rsp_valid,
  input  logic [CODE_W-1:0] tlb_rsp_code,
  input  logic [ADDR_W-1:0] tlb_rsp_paddr,
  input  logic [1:0]        tlb_rsp_perm,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_paddr,
  output logic [1:0]        out_perm
);
  localparam int OFF_W = ADDR_W - 3;

  route_e            route;
  logic [ADDR_W-1:0] dir_paddr;
  logic [CODE_W-1:0] dir_code;
  logic [1:0]        dir_perm;
  logic              busy;
  logic              rsp_take;
  logic              req_fire;

  assign req_ready = ~busy;
  assign req_fire  = req_valid & req_ready;

  vsd_classify #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_classify (
    .vaddr        (req_vaddr),
    .mode         (req_mode),
    .erl          (req_erl),
    .route        (route),
    .direct_paddr (dir_paddr),
    .direct_code  (dir_code),
    .direct_perm  (dir_perm)
  );

  vsd_tlb_port #(.ADDR_W(ADDR_W)) u_tlb_port (
    .clk           (clk),
    .rst           (rst),
    .issue         (req_fire && route == RT_TLB),
    .vaddr         (req_vaddr),
    .rsp_valid     (tlb_rsp_valid),
    .tlb_req_valid (tlb_req_valid),
    .tlb_req_vaddr (tlb_req_vaddr),
    .busy          (busy),
    .rsp_take      (rsp_take)
  );

  vsd_result_reg #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_result (
    .clk          (clk),
    .rst          (rst),
    .direct_load  (req_fire && route != RT_TLB),
    .direct_code  (dir_code),
    .direct_paddr (dir_paddr),
    .direct_perm  (dir_perm),
    .rsp_take     (rsp_take),
    .rsp_code     (tlb_rsp_code),
    .rsp_paddr    (tlb_rsp_paddr),
    .rsp_perm     (tlb_rsp_perm),
    .out_valid    (out_valid),
    .out_code     (out_code),
    .out_paddr    (out_paddr),
    .out_perm     (out_perm)
  );

  AST_ERL_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (req_fire && req_erl && !req_vaddr[ADDR_W-1]) |=>
      out_valid && out_paddr == $past(req_vaddr) && out_code == CODE_W'(RES_MATCH)); // R3
  AST_USEG_TO_TLB: assert property (@(posedge clk) disable iff (rst)
    (req_fire && !req_erl && !req_vaddr[ADDR_W-1]) |=>
      tlb_req_valid && tlb_req_vaddr == $past(req_vaddr) && !out_valid); // R2
  AST_KSEG0_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (req_fire && req_mode == MODE_KERNEL && req_vaddr[ADDR_W-1 -: 3] == 3'b100) |=>
      out_valid && out_paddr == {3'b000, $past(req_vaddr[OFF_W-1:0])}); // R4
  AST_USER_KERNEL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_fire && req_mode[1] && req_vaddr[ADDR_W-1]) |=>
      out_valid && out_code == CODE_W'(RES_BADADDR) && out_perm == PERM_NONE && !tlb_req_valid); // R6
  AST_NO_RESULT_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    tlb_req_valid |-> !out_valid); // R11
endmodule

// File: tb/test_virt_seg_decoder.sv
module test_virt_seg_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_mode = 2'b00;
  logic        req_erl = 1'b0;
  logic        tlb_req_valid;
  logic [31:0] tlb_req_vaddr;
  logic        tlb_rsp_valid = 1'b0;
  logic [2:0]  tlb_rsp_code = '0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic [1:0]  tlb_rsp_perm = '0;
  logic        out_valid;
  logic [2:0]  out_code;
  logic [31:0] out_paddr;
  logic [1:0]  out_perm;

  int checks = 0;
  int errors = 0;
  int rsp_lat = 0;

  logic [2:0]  exp_code_q[$];
  logic [31:0] exp_paddr_q[$];
  logic [1:0]  exp_perm_q[$];
  string       exp_tag_q[$];
  logic [31:0] tlb_q[$];

  always #2 clk = ~clk;

  virt_seg_decoder i_virt_seg_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_mode(req_mode), .req_erl(req_erl),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vaddr(tlb_req_vaddr),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_perm(tlb_rsp_perm),
    .out_valid(out_valid), .out_code(out_code), .out_paddr(out_paddr), .out_perm(out_perm)
  );

  // TLB model answers
  function automatic logic [2:0] tlb_code_of(input logic [31:0] va);
    case (va[1:0])
      2'd0: return 3'd0;
      2'd1: return 3'd2;
      2'd2: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
  function automatic logic [31:0] tlb_paddr_of(input logic [31:0] va);
    return {va[31:12] ^ 20'hABCDE, va[11:0]};
  endfunction

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] va, input logic [1:0] md, input logic erl, input string tag);
    logic [2:0] seg;
    logic       kern, sup;
    bit         to_tlb;
    logic [2:0] c;
    logic [31:0] p;
    logic [1:0] pm;
    seg  = va[31:29];
    kern = (md == 2'b00);
    sup  = (md == 2'b01);
    to_tlb = 0; c = 3'd1; p = '0; pm = 2'b00;
    if (!seg[2]) begin
      if (erl) begin c = 3'd0; p = va; pm = 2'b11; end
      else to_tlb = 1;
    end else if (seg == 3'b100 || seg == 3'b101) begin
      if (kern) begin c = 3'd0; p = {3'b000, va[28:0]}; pm = 2'b11; end
    end else if (seg == 3'b110) begin
      if (kern || sup) to_tlb = 1;
    end else begin
      if (kern) to_tlb = 1;
    end
    if (to_tlb) begin
      c = tlb_code_of(va); p = tlb_paddr_of(va); pm = va[3:2];
      tlb_q.push_back(va);
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_mode = md; req_erl = erl;
    exp_code_q.push_back(c); exp_paddr_q.push_back(p);
    exp_perm_q.push_back(pm); exp_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_code_q.size() == 0) begin
          check("R11 unexpected result", 0, $sformatf("paddr=%h", out_paddr), "no result");
        end else begin
          string t;
          logic [2:0] c;
          logic [31:0] p;
          logic [1:0] pm;
          t = exp_tag_q.pop_front(); c = exp_code_q.pop_front();
          p = exp_paddr_q.pop_front(); pm = exp_perm_q.pop_front();
          check(t, out_code == c && out_paddr == p && out_perm == pm,
                $sformatf("code=%0d paddr=%h perm=%b", out_code, out_paddr, out_perm),
                $sformatf("code=%0d paddr=%h perm=%b", c, p, pm));
        end
      end
    end
  end

  // TLB responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tlb_req_valid) begin
        logic [31:0] va;
        if (tlb_q.size() == 0) begin
          check("R6 unexpected TLB request", 0, $sformatf("vaddr=%h", tlb_req_vaddr), "none");
          va = tlb_req_vaddr;
        end else begin
          va = tlb_q.pop_front();
          check("R2 TLB request address", tlb_req_vaddr == va,
                $sformatf("%h", tlb_req_vaddr), $sformatf("%h", va));
        end
        repeat (rsp_lat) @(negedge clk);
        tlb_rsp_valid = 1'b1; tlb_rsp_code = tlb_code_of(va);
        tlb_rsp_paddr = tlb_paddr_of(va); tlb_rsp_perm = va[3:2];
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", out_valid == 0 && tlb_req_valid == 0 && req_ready == 1,
          $sformatf("v=%b t=%b r=%b", out_valid, tlb_req_valid, req_ready), "v=0 t=0 r=1");

    // R3 identity with error level, every mode
    send(32'h0000_0000, 2'b10, 1'b1, "R3 erl user low");
    send(32'h7FFF_FFFF, 2'b00, 1'b1, "R3 erl kernel top");
    send(32'h1234_5678, 2'b01, 1'b1, "R3 erl super");
    // R4 / R5 kernel windows, boundaries
    send(32'h8000_0000, 2'b00, 1'b0, "R4 kseg0 base");
    send(32'h9FFF_FFFF, 2'b00, 1'b0, "R4 kseg0 top");
    send(32'hA000_0000, 2'b00, 1'b0, "R5 kseg1 base");
    send(32'hBFFF_FFFF, 2'b00, 1'b1, "R5 kseg1 top erl");
    // R6 faults
    send(32'h8000_1000, 2'b01, 1'b0, "R6 kseg0 super");
    send(32'hA123_4560, 2'b10, 1'b0, "R6 kseg1 user");
    send(32'hE000_0000, 2'b01, 1'b0, "R6 kseg3 super");
    send(32'hFFFF_FFFF, 2'b10, 1'b0, "R6 kseg3 user");
    // R10 reserved mode as user
    send(32'h8800_0000, 2'b11, 1'b0, "R10 mode11 kseg0");
    send(32'hC000_0000, 2'b11, 1'b0, "R10 mode11 ksseg");
    // R2 / R7 / R8 mapped, zero latency
    rsp_lat = 0;
    send(32'h7FFF_FFFC, 2'b10, 1'b0, "R2 useg user");
    send(32'h0000_1001, 2'b00, 1'b0, "R2 useg kernel");
    send(32'hC000_0006, 2'b01, 1'b0, "R7 ksseg super");
    send(32'hDFFF_FFFF, 2'b00, 1'b0, "R7 ksseg kernel");
    send(32'hDFFF_0000, 2'b10, 1'b0, "R7 ksseg user");
    send(32'hE000_000B, 2'b00, 1'b0, "R8 kseg3 kernel");
    send(32'hFFFF_FFFE, 2'b00, 1'b0, "R8 kseg3 top");

    // R9 / R12: long latency, stray requests while busy
    rsp_lat = 4;
    send(32'h0040_0003, 2'b10, 1'b0, "R9 long latency");
    check("R9 ready low while open", req_ready == 1'b0, $sformatf("%b", req_ready), "0");
    req_valid = 1'b1; req_vaddr = 32'h8000_0040; req_mode = 2'b00; req_erl = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    check("R12 no result while busy", out_valid == 1'b0, $sformatf("%b", out_valid), "0");
    send(32'h9000_0000, 2'b00, 1'b0, "R12 next after busy");
    rsp_lat = 1;
    send(32'hC000_0009, 2'b00, 1'b0, "R11 mixed order mapped");
    send(32'hA000_0010, 2'b00, 1'b0, "R11 mixed order direct");

    repeat (20) @(negedge clk);
    check("R11 all results seen", exp_code_q.size() == 0 && tlb_q.size() == 0,
          $sformatf("%0d/%0d left", exp_code_q.size(), tlb_q.size()), "0/0 left");
    finish_run();
  end
endmodule